// File: doc/BRIEF.md
# Compare and Test Flag Unit

This block takes two unsigned operands and an operation select. It updates a condition-flags word that it keeps in a register. A compare operation sets the zero and carry flags from an unsigned magnitude comparison of A against B. A test operation computes the bitwise AND of the operands and updates only the zero flag. No operation changes any flag bit except the ones it is defined to write. This matters because the same word also holds the mode and interrupt-enable bits.

An update happens only on a clock edge where the valid strobe is high. On any other edge the flags word keeps its value. The zero and carry positions are parameters, so the block can sit in front of other flag layouts. The default layout puts carry at bit 0 and zero at bit 3.

Top module: `cmpflag_unit`

## Requirements
- R1: While rst_n is low at a clock edge, flags_q becomes all zeros on that edge.
- R2: When a compare (op_sel=0) is accepted with A equal to B, the next flags_q has bit 3 (zero) set and bit 0 (carry) clear.
- R3: When a compare is accepted with A less than B as unsigned numbers, the next flags_q has bit 3 clear and bit 0 set.
- R4: When a compare is accepted with A greater than B as unsigned numbers, the next flags_q has bits 3 and 0 both clear.
- R5: When a test (op_sel=1) is accepted, bit 3 of the next flags_q is set if A AND B is zero and is clear otherwise. Bit 0 keeps its previous value.
- R6: An accepted operation leaves every bit other than bits 0 and 3 at its previous value. For a test, that holds for every bit other than bit 3.
- R7: On an edge with valid low, flags_q does not change, whatever the operands and op_sel are.
- R8: When a compare is accepted with both operands all ones, bit 3 is set and bit 0 is clear. When a test is accepted with both operands all ones, bit 3 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid | input | 1 | Accept the operation on this edge |
| op_sel | input | 1 | 0 = compare, 1 = test |
| opnd_a | input | 64 | Operand A |
| opnd_b | input | 64 | Operand B |
| flags_in_load | input | 1 | Load flags_in into the flag register, so the untouched bits can be seeded |
| flags_in | input | 64 | Value loaded when flags_in_load is high |
| flags_q | output | 64 | Registered flags word |

## Verification
The bench builds the block with its default parameters: a 64-bit datapath, carry at bit 0 and zero at bit 3. With those values the all-ones operand case and the top-bit differences can be reached. Those are the cases where an unsigned comparison done as a signed one would go wrong. It seeds the other flag bits with patterns such as all ones, which makes any stray write to a preserved bit visible.

// File: rtl/cmpflag_pkg.sv
// Package: shared operation encoding for the compare/test flag unit.
// Assumes: one select bit distinguishes the two operations.
package cmpflag_pkg;
    typedef enum logic {
        OP_CMP  = 1'b0,
        OP_TEST = 1'b1
    } flag_op_e;

    // Flag update request produced by the evaluators.
    typedef struct packed {
        logic zf_we;
        logic zf_val;
        logic cf_we;
        logic cf_val;
    } flag_upd_t;
endpackage

// File: rtl/cmpflag_magcmp.sv
// Module: unsigned magnitude comparator producing equal / less indications.
// Assumes: operands are unsigned and of width W.
module cmpflag_magcmp #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         eq,
    output logic         lt
);
    // Purpose: derive equality and unsigned less-than from a wide subtract.
    logic [W:0] diff;
    always_comb begin
        diff = {1'b0, a} - {1'b0, b};
        lt   = diff[W];
        eq   = (diff[W-1:0] == '0) && !diff[W];
    end
endmodule

// File: rtl/cmpflag_andzero.sv
// Module: bitwise-AND zero detector for the test operation.
// Assumes: W is at least 1.
module cmpflag_andzero #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         zero
);
    // Purpose: flag when no bit is common to both operands.
    always_comb zero = ((a & b) == '0);
endmodule

// File: rtl/cmpflag_unit.sv
// Module: top of the compare/test flag unit; holds the flags register.
// Assumes: CF_BIT and ZF_BIT are distinct and within the flags width.
module cmpflag_unit
    import cmpflag_pkg::*;
#(
    parameter int W      = 64,
    parameter int FW     = 64,
    parameter int CF_BIT = 0,
    parameter int ZF_BIT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid,
    input  logic          op_sel,
    input  logic [W-1:0]  opnd_a,
    input  logic [W-1:0]  opnd_b,
    input  logic          flags_in_load,
    input  logic [FW-1:0] flags_in,
    output logic [FW-1:0] flags_q
);
    localparam logic [FW-1:0] CF_MASK = FW'(1) << CF_BIT;
    localparam logic [FW-1:0] ZF_MASK = FW'(1) << ZF_BIT;

    logic      eq, lt, and_zero;
    flag_upd_t upd;
    logic [FW-1:0] flags_d;

    cmpflag_magcmp #(.W(W)) u_cmp (.a(opnd_a), .b(opnd_b), .eq(eq), .lt(lt));
    cmpflag_andzero #(.W(W)) u_and (.a(opnd_a), .b(opnd_b), .zero(and_zero));

    // Purpose: choose which flags to write and with what values.
    always_comb begin
        upd = '0;
        if (flag_op_e'(op_sel) == OP_CMP) begin
            upd.zf_we  = 1'b1;
            upd.zf_val = eq;
            upd.cf_we  = 1'b1;
            upd.cf_val = lt;
        end else begin
            upd.zf_we  = 1'b1;
            upd.zf_val = and_zero;
        end
    end

    // Purpose: merge the update into the current flags word.
    always_comb begin
        flags_d = flags_q;
        if (upd.zf_we) flags_d[ZF_BIT] = upd.zf_val;
        if (upd.cf_we) flags_d[CF_BIT] = upd.cf_val;
    end

    // Purpose: flags register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n)             flags_q <= '0;
        else if (flags_in_load) flags_q <= flags_in;
        else if (valid)         flags_q <= flags_d;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> flags_q == '0);
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && !flags_in_load) |=> $stable(flags_q));
    assert_cmp_eq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !flags_in_load && !op_sel && opnd_a == opnd_b)
        |=> (flags_q[ZF_BIT] && !flags_q[CF_BIT]));
    assert_cmp_lt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !flags_in_load && !op_sel && opnd_a < opnd_b)
        |=> (!flags_q[ZF_BIT] && flags_q[CF_BIT]));
    assert_cmp_gt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !flags_in_load && !op_sel && opnd_a > opnd_b)
        |=> (!flags_q[ZF_BIT] && !flags_q[CF_BIT]));
    assert_test_cf_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !flags_in_load && op_sel) |=> $stable(flags_q[CF_BIT]));
    assert_preserve_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !flags_in_load)
        |=> ((flags_q & ~(CF_MASK | ZF_MASK)) == ($past(flags_q) & ~(CF_MASK | ZF_MASK))));
endmodule

// File: tb/sim_cmpflag_unit.sv
module sim_cmpflag_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        valid;
    logic        op_sel;
    logic [63:0] opnd_a, opnd_b;
    logic        flags_in_load;
    logic [63:0] flags_in;
    logic [63:0] flags_q;

    int total = 0;
    int bad   = 0;
    logic [63:0] model;

    always #4 clk = ~clk;   // 125 MHz

    cmpflag_unit u0 (.clk(clk), .rst_n(rst_n), .valid(valid), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .flags_in_load(flags_in_load),
        .flags_in(flags_in), .flags_q(flags_q));

    localparam int NV = 10;
    // {op, a, b, seed}
    localparam logic [192:0] VEC [NV] = '{
        {1'b0, 64'd5, 64'd5, 64'h0},
        {1'b0, 64'd3, 64'd9, 64'hFFFF_FFFF_FFFF_FFFF},
        {1'b0, 64'd9, 64'd3, 64'hFFFF_FFFF_FFFF_FFFF},
        {1'b0, 64'h8000_0000_0000_0000, 64'h1, 64'h3_0076},
        {1'b0, 64'h1, 64'h8000_0000_0000_0000, 64'h0},
        {1'b0, '1, '1, 64'h0},
        {1'b1, 64'hF0, 64'h0F, 64'h1},
        {1'b1, 64'hF0, 64'h10, 64'hFFFF_FFFF_FFFF_FFFF},
        {1'b1, '1, '1, 64'h9},
        {1'b1, 64'h0, '1, 64'h3_0000}
    };

    task automatic check(input string req, input logic [63:0] exp);
        total++;
        if (flags_q !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, flags_q, exp);
        end
    endtask

    function automatic logic [63:0] ref_op(input logic op, input logic [63:0] a,
                                           input logic [63:0] b, input logic [63:0] f);
        logic [63:0] r = f;
        if (!op) begin
            r[3] = (a == b);
            r[0] = (a < b);
        end else r[3] = ((a & b) == 0);
        return r;
    endfunction

    task automatic seed(input logic [63:0] v);
        @(negedge clk); flags_in_load = 1'b1; flags_in = v; valid = 1'b0;
        @(negedge clk); flags_in_load = 1'b0;
    endtask

    task automatic run_op(input logic op, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk); valid = 1'b1; op_sel = op; opnd_a = a; opnd_b = b;
        model = ref_op(op, a, b, flags_q);
        @(negedge clk); valid = 1'b0;
    endtask

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; valid = 1'b0; op_sel = 1'b0; opnd_a = '0; opnd_b = '0;
        flags_in_load = 1'b0; flags_in = '0;
        repeat (3) @(negedge clk);
        check("R1", 64'h0);
        rst_n = 1'b1;

        // Table walk: R2 R3 R4 R5 R6 R8
        for (int i = 0; i < NV; i++) begin
            seed(VEC[i][63:0]);
            run_op(VEC[i][192], VEC[i][191:128], VEC[i][127:64]);
            check($sformatf("R2/R3/R4/R5/R6/R8 vec%0d", i), model);
        end

        // R7: valid low with operands that would change flags
        seed(64'h8);
        @(negedge clk); op_sel = 1'b0; opnd_a = 64'd1; opnd_b = 64'd2; valid = 1'b0;
        @(negedge clk);
        check("R7", 64'h8);

        // R5: test keeps carry set
        seed(64'h1);
        run_op(1'b1, 64'h3, 64'h4);
        check("R5 cf kept", 64'h9);

        // R8: compare all ones over fully seeded word
        seed(64'hFFFF_FFFF_FFFF_FFFF);
        run_op(1'b0, '1, '1);
        check("R8 cmp ones", 64'hFFFF_FFFF_FFFF_FFFE);

        // R1: reset mid-run clears
        seed(64'h3_0079);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid", 64'h0);
        rst_n = 1'b1;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule